// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a simple processor core and decides when a device request turns into an interrupt. Each request line has a fixed urgency. Source `i` carries level `i+1`, so the highest-numbered line is the most urgent. A request is latched as pending and stays pending until software clears it. The controller keeps a current priority level and a global enable bit. Software sees and changes both through a small register port. The controller also offers an interrupt to the core only at an instruction boundary that the core signals, so an instruction already in flight is never cut short.

When an interrupt is taken, the controller does three things in the same cycle. It pushes the interrupted PC, the current level and the current mode onto a four-entry hardware stack. It clears the global enable. It enters supervisor mode. The handler is expected to raise the level to its own source's level and then set the enable again. After that, only a strictly more urgent source can preempt it. To leave, the handler clears its request, disables interrupts and issues the return command. The return pops the top frame: it hands back the saved PC, restores the saved level and mode, and sets the enable again. Nested entries stack up in this way and unwind in reverse order. An entry that arrives while the stack is full sets a sticky overflow flag.

The take and return signals are plain control pins and have no valid/ready handshake. The core's `boundary_i` acts as the acceptance: a `take_o` that is high at a clock edge while `boundary_i` is high is committed. The return is accepted in any cycle in which the stack is not empty.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the following all read 0: the global enable, the current level, the supervisor bit, the overflow flag, the stack depth and every pending bit. `take_o` stays low.
- R2: A request line that is high at a clock edge sets its pending bit (register address 1, bit `i` for source `i`). The bit stays set after the line falls. It clears only when a 1 is written to that bit at address 1. If the line is still high during that write, the bit stays pending.
- R3: `take_o` is high only when all of these hold: `boundary_i` is high, the global enable is 1, and some pending source has a level (`i+1`) strictly greater than the current level. A source whose level equals the current level is not eligible.
- R4: Among the eligible sources, `vector_o` gives the index of the one with the highest level.
- R5: A take that is committed at a clock edge has these effects from the next cycle on: the global enable is 0, the supervisor bit is 1, the stack depth has gone up by one, and the current level is unchanged.
- R6: A write to address 0 sets the global enable from bit 0 and the current level from bits [3:1]. Reading address 0 returns the same encoding.
- R7: While `ret_i` is high and the stack is not empty, `ret_valid_o` is high and `ret_pc_o` shows the PC saved by the latest entry. From the next cycle on, the saved level and mode are restored, the global enable is 1, and the depth is one lower.
- R8: Nested entries return in last-in first-out order. The PCs come back in the reverse of the order in which they were saved, and so do the levels and modes.
- R9: A take committed when the depth is already 4 is still signalled on `take_o`. It stores no frame, leaves the depth at 4 and sets the overflow flag. The flag stays set until reset. The status register is address 2: bit 0 is supervisor, bit 1 is overflow and bits [4:2] are the depth.
- R10: A return command while the stack is empty is ignored. `ret_valid_o` stays low and no register changes.
- R11: `take_o` is held low in any cycle in which `ret_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC | Level-sensitive device request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 pending/clear, 2 status) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the current address |
| boundary_i | input | 1 | Core is between instructions and can accept an interrupt |
| pc_i | input | PC_W | PC to resume at if an interrupt is taken now |
| take_o | output | 1 | Interrupt taken at this edge when boundary_i is high |
| vector_o | output | IDX_W | Index of the winning source |
| ret_i | input | 1 | Return-from-exception command |
| ret_valid_o | output | 1 | Return accepted this cycle |
| ret_pc_o | output | PC_W | PC to resume at on an accepted return |

## Verification
The assertions take several things for granted about the inputs. They assume that `boundary_i` and `ret_i` are clean single-bit levels sampled at the clock edge. They assume that a return is issued only after the handler has cleared the global enable, as the exit order prescribes. The stimulus changes every input one time unit after a rising edge. It opens the boundary only for the cycles in which a take is meant to commit, and it issues returns only after a write that clears the enable, or while the stack is deliberately empty.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_PEND = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  // The clear is applied first; a line still high re-sets its bit.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | irq_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NUM_SRC = 4,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] elig;

  // Source i carries level i+1.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = pend_i[g] && (LVL_W'(g + 1) > cur_lvl_i);
  end

  // Scan upward so the highest eligible index wins.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int DEPTH   = 4,
  parameter int FRAME_W = 20,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] top_o,
  output logic               full_o,
  output logic               empty_o,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [FRAME_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]   cnt_q;
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;

  assign wr_ptr  = PTR_W'(cnt_q);
  assign rd_ptr  = PTR_W'(cnt_q - CNT_W'(1));
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem[rd_ptr];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      mem[wr_ptr] <= frame_i;
      cnt_q       <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int PC_W      = 16,
  parameter int DATA_W    = 8,
  parameter int STK_DEPTH = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               boundary_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   vector_o,
  input  logic               ret_i,
  output logic               ret_valid_o,
  output logic [PC_W-1:0]    ret_pc_o
);
  localparam int LVL_W   = $clog2(NUM_SRC + 1);
  localparam int CNT_W   = $clog2(STK_DEPTH + 1);
  localparam int FRAME_W = PC_W + LVL_W + 1;

  logic               gie_q, sup_q, ovf_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [NUM_SRC-1:0] pend, clr;
  logic               any_elig;
  logic [FRAME_W-1:0] push_frame, top_frame;
  logic               stk_full, stk_empty;
  logic [CNT_W-1:0]   depth;
  logic               pop;
  logic               wr_ctrl;
  logic [LVL_W-1:0]   top_lvl;
  logic               top_sup;

  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign clr     = (reg_we_i && reg_addr_i == A_PEND) ? reg_wdata_i[NUM_SRC-1:0] : '0;

  irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr), .pend_o(pend)
  );

  irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i(pend), .cur_lvl_i(lvl_q), .any_o(any_elig), .idx_o(vector_o)
  );

  assign take_o     = boundary_i && gie_q && any_elig && !ret_i;
  assign pop        = ret_i && !stk_empty;
  assign push_frame = {pc_i, lvl_q, sup_q};

  irq_stack #(.DEPTH(STK_DEPTH), .FRAME_W(FRAME_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(take_o), .pop_i(pop),
    .frame_i(push_frame), .top_o(top_frame), .full_o(stk_full),
    .empty_o(stk_empty), .cnt_o(depth)
  );

  assign ret_pc_o    = top_frame[FRAME_W-1 -: PC_W];
  assign top_lvl     = top_frame[LVL_W:1];
  assign top_sup     = top_frame[0];
  assign ret_valid_o = pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sup_q <= 1'b0;
      ovf_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      if (take_o && stk_full) ovf_q <= 1'b1;
      if (take_o) begin
        gie_q <= 1'b0;
        sup_q <= 1'b1;
      end else if (pop) begin
        gie_q <= 1'b1;
        lvl_q <= top_lvl;
        sup_q <= top_sup;
      end else if (wr_ctrl) begin
        gie_q <= reg_wdata_i[0];
        lvl_q <= reg_wdata_i[LVL_W:1];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[0]       = gie_q;
        reg_rdata_o[LVL_W:1] = lvl_q;
      end
      A_PEND: reg_rdata_o[NUM_SRC-1:0] = pend;
      A_STAT: begin
        reg_rdata_o[0]         = sup_q;
        reg_rdata_o[1]         = ovf_q;
        reg_rdata_o[CNT_W+1:2] = depth;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int NUM_SRC   = 4,
  parameter int STK_DEPTH = 4,
  localparam int LVL_W = $clog2(NUM_SRC + 1),
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W = $clog2(STK_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take,
  input logic             boundary,
  input logic             ret,
  input logic             ret_valid,
  input logic [IDX_W-1:0] vector,
  input logic             gie,
  input logic             sup,
  input logic             ovf,
  input logic [LVL_W-1:0] lvl,
  input logic [CNT_W-1:0] depth
);
  logic [LVL_W:0] win_lvl;
  assign win_lvl = (LVL_W + 1)'(vector) + (LVL_W + 1)'(1);

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gie && boundary)); // R3
  AST_WIN_ABOVE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (win_lvl > {1'b0, lvl})); // R3
  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sup && !gie)); // R5
  AST_ENTRY_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> $stable(lvl)); // R5
  AST_NO_TAKE_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
    ret |-> !take); // R11
  AST_RET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && depth == '0) |-> !ret_valid); // R10
  AST_RET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> gie); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(STK_DEPTH)); // R9
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NUM_SRC(NUM_SRC), .STK_DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take_o), .boundary(boundary_i), .ret(ret_i),
  .ret_valid(ret_valid_o), .vector(vector_o), .gie(gie_q), .sup(sup_q),
  .ovf(ovf_q), .lvl(lvl_q), .depth(depth)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       boundary = 1'b0;
  logic [15:0] pc = '0;
  logic       take;
  logic [1:0] vec;
  logic       ret = 1'b0;
  logic       ret_valid;
  logic [15:0] ret_pc;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .boundary_i(boundary), .pc_i(pc),
    .take_o(take), .vector_o(vec), .ret_i(ret), .ret_valid_o(ret_valid),
    .ret_pc_o(ret_pc)
  );

  // Fields: {vec[10:9], take[8], gie[7], lvl[6:4], mask[3:0]}
  localparam logic [10:0] VEC [10] = '{
    {2'd0, 1'b1, 1'b1, 3'd0, 4'b0001},
    {2'd1, 1'b1, 1'b1, 3'd0, 4'b0011},
    {2'd3, 1'b1, 1'b1, 3'd0, 4'b1010},
    {2'd0, 1'b0, 1'b0, 3'd0, 4'b1111},
    {2'd0, 1'b0, 1'b1, 3'd3, 4'b0100},
    {2'd2, 1'b1, 1'b1, 3'd2, 4'b0100},
    {2'd2, 1'b1, 1'b1, 3'd2, 4'b0110},
    {2'd0, 1'b0, 1'b1, 3'd4, 4'b1001},
    {2'd0, 1'b0, 1'b1, 3'd0, 4'b0000},
    {2'd3, 1'b1, 1'b1, 3'd3, 4'b1001}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input int exp);
    addr = a;
    #0.5;
    chk(tag, int'(rdata), exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd("R1 ctrl", 2'd0, 0);
    rd("R1 pend", 2'd1, 0);
    rd("R1 stat", 2'd2, 0);
    irq = 4'b1111; boundary = 1'b1; #0.5;
    chk("R1 take", int'(take), 0);
    boundary = 1'b0; irq = '0;
    tick();
    wr(2'd1, 8'h0F);

    // R2 pending latch and clear
    irq = 4'b0110; tick(); irq = 4'b0100; tick();
    rd("R2 latched", 2'd1, 4'b0110);
    wr(2'd1, 8'h06);
    rd("R2 held line", 2'd1, 4'b0100);
    irq = '0; wr(2'd1, 8'h04);
    rd("R2 cleared", 2'd1, 0);

    // R6 control register
    wr(2'd0, 8'h05);
    rd("R6 ctrl", 2'd0, 5);

    // R3/R4 eligibility and arbitration table
    for (int i = 0; i < 10; i++) begin
      logic [10:0] v;
      v = VEC[i];
      wr(2'd1, 8'h0F);
      wr(2'd0, {4'd0, v[6:4], v[7]});
      irq = v[3:0]; tick(); irq = '0;
      boundary = 1'b1; #0.5;
      chk($sformatf("R3 take row %0d", i), int'(take), int'(v[8]));
      if (v[8]) chk($sformatf("R4 vec row %0d", i), int'(vec), int'(v[10:9]));
      boundary = 1'b0;
      tick();
    end

    // R5/R7/R8 nested entry and return
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h01);
    irq = 4'b0001; tick();
    pc = 16'h1000; boundary = 1'b1; #0.5;
    chk("R5 take outer", int'(take), 1);
    chk("R4 vec outer", int'(vec), 0);
    tick(); boundary = 1'b0;
    rd("R5 stat outer", 2'd2, 5);
    rd("R5 ctrl outer", 2'd0, 0);
    irq = '0; wr(2'd1, 8'h01);
    wr(2'd0, 8'h03);
    irq = 4'b1000; tick();
    pc = 16'h2000; boundary = 1'b1; #0.5;
    chk("R8 take inner", int'(take), 1);
    chk("R4 vec inner", int'(vec), 3);
    tick(); boundary = 1'b0;
    rd("R8 stat inner", 2'd2, 9);
    irq = '0; wr(2'd1, 8'h08);
    wr(2'd0, 8'h08);
    ret = 1'b1; #0.5;
    chk("R7 ret valid", int'(ret_valid), 1);
    chk("R8 ret pc inner", int'(ret_pc), 16'h2000);
    tick(); ret = 1'b0;
    rd("R7 ctrl after ret", 2'd0, 3);
    rd("R7 stat after ret", 2'd2, 5);
    wr(2'd0, 8'h02);
    ret = 1'b1; #0.5;
    chk("R8 ret pc outer", int'(ret_pc), 16'h1000);
    tick(); ret = 1'b0;
    rd("R8 ctrl final", 2'd0, 1);
    rd("R8 stat final", 2'd2, 0);

    // R10 return with empty stack
    ret = 1'b1; #0.5;
    chk("R10 ret valid", int'(ret_valid), 0);
    tick(); ret = 1'b0;
    rd("R10 ctrl", 2'd0, 1);
    rd("R10 stat", 2'd2, 0);

    // R11 take held off during return
    irq = 4'b0001; tick(); irq = '0;
    boundary = 1'b1; ret = 1'b1; #0.5;
    chk("R11 take", int'(take), 0);
    tick(); ret = 1'b0; #0.5;
    rd("R11 stat", 2'd2, 0);
    chk("R11 take after", int'(take), 1);
    boundary = 1'b0;

    // R9 overflow
    for (int k = 0; k < 4; k++) begin
      pc = 16'h3000 + 16'(k);
      boundary = 1'b1; tick(); boundary = 1'b0;
      wr(2'd0, 8'h01);
    end
    rd("R9 stat full", 2'd2, 17);
    boundary = 1'b1; #0.5;
    chk("R9 take when full", int'(take), 1);
    tick(); boundary = 1'b0;
    rd("R9 stat ovf", 2'd2, 19);
    wr(2'd0, 8'h00);
    ret = 1'b1; #0.5;
    chk("R9 ret pc top", int'(ret_pc), 16'h3003);
    tick(); ret = 1'b0;
    rd("R9 ovf sticky", 2'd2, 15);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule